// File: doc/BRIEF.md
# Miller-Rabin Primality Tester

This block decides whether one odd 32-bit candidate is a probable prime, using the Miller-Rabin strong-pseudoprime test. A candidate and a round count are offered with a valid/ready handshake. The block reports the result as a flag together with a one-cycle completion pulse. Internally it first strips the trailing zero bits of n−1, which splits it into 2^s·d with d odd. It then runs up to k rounds. Each round raises a witness base to the power d modulo n, and if needed squares the result repeatedly. The test stops at the first round that proves the candidate composite.

All arithmetic uses one bit-serial modular multiplier with double-width intermediates. That multiplier sits inside a right-to-left square-and-multiply exponentiation engine. The tester's squaring steps go through the same engine with an exponent of two. A caller that feeds candidates from a generator waits for the done pulse and reads the flag in the same cycle. The flag then stays put until the next candidate is accepted.

Top module: `mr_prime_tester`

## Requirements
- R1: `in_ready` is high exactly while the block is idle, and a candidate is taken on a cycle where `in_valid` and `in_ready` are both high. From the next cycle `busy` is high and `in_ready` is low. Both stay so up to and including the cycle of `done`.
- R2: `done` is high for a single cycle, and `busy` is low in the cycle after it. `is_prime` holds the verdict during `done` and keeps it until the next accept. It reads 0 from the cycle after an accept until the verdict.
- R3: Before any round, n−1 is written as 2^s·d with d odd, with s equal to the number of trailing zero bits of n−1.
- R4: Round i, counted from 0, uses the i-th entry of the ordered base list 2, 3, 5, 7, 11, 13, 17. A base not below n−1 is skipped, and that round counts as passed.
- R5: A round computes x = a^d mod n and passes at once if x is 1 or n−1.
- R6: Otherwise x is squared modulo n at most s−1 times. Reaching n−1 passes the round. Reaching 1, or running out of squarings, marks n composite.
- R7: A composite finding ends the test at once, and later rounds do not run, so the latency does not depend on the remaining round count.
- R8: If all rounds pass, `is_prime` is 1. The candidate 2750263 is reported prime for any round count.
- R9: `in_rounds` is a 3-bit round count k, and k = 0 behaves exactly like k = 1, in both verdict and latency.
- R10: Every result produced by the exponentiation engine is below n.
- R11: After reset, `in_ready` is 1, and `busy`, `done` and `is_prime` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Candidate offered |
| in_ready | output | 1 | Block idle, candidate can be taken |
| in_cand | input | 32 | Odd candidate n, greater than 2 |
| in_rounds | input | 3 | Round count k (0 acts as 1) |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| is_prime | output | 1 | 1 = probable prime, 0 = composite |

## Verification
The handshake outputs are due one cycle after the accepting edge. The bench samples `busy`, `in_ready` and the cleared flag on the falling edge that follows. The verdict arrives after a number of cycles that depends on the data, so the bench counts falling edges from the accept until `done` is seen. It samples `is_prime` in that same half-cycle, and checks one edge later that the pulse has dropped and the flag has held. The recorded latencies themselves are compared for R7 and R9: the strong pseudoprime 2047 must take the same number of cycles with k = 2 and k = 7, and with k = 0 and k = 1.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    localparam int MRP_W      = 32;
    localparam int MRP_NBASES = 7;

    typedef enum logic [2:0] {
        EX_IDLE,
        EX_CHECK,
        EX_WAIT_R,
        EX_SQUARE,
        EX_WAIT_P
    } exp_state_t;

    typedef enum logic [2:0] {
        T_IDLE,
        T_SPLIT,
        T_PICK,
        T_POW,
        T_SQR,
        T_FIN
    } top_state_t;

    // Ordered witness list; index beyond the list yields 0 (never used).
    function automatic logic [7:0] witness_base(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'd2;
            3'd1:    return 8'd3;
            3'd2:    return 8'd5;
            3'd3:    return 8'd7;
            3'd4:    return 8'd11;
            3'd5:    return 8'd13;
            3'd6:    return 8'd17;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/mrp_modmul.sv
module mrp_modmul #(
    parameter int W = mrp_pkg::MRP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] modulus,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc, aa, bb, mm;
    logic [CW-1:0] cnt;
    logic          run;

    logic [2*W-1:0] dbl_w, mod_w, add_w, sum_w;
    logic [W-1:0]   dbl_red, acc_nx;

    always_comb begin
        mod_w   = {{W{1'b0}}, mm};
        dbl_w   = {{W{1'b0}}, acc} << 1;
        dbl_red = (dbl_w >= mod_w) ? W'(dbl_w - mod_w) : W'(dbl_w);
        add_w   = bb[W-1] ? {{W{1'b0}}, aa} : '0;
        sum_w   = {{W{1'b0}}, dbl_red} + add_w;
        acc_nx  = (sum_w >= mod_w) ? W'(sum_w - mod_w) : W'(sum_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            aa     <= '0;
            bb     <= '0;
            mm     <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (start && !run) begin
                acc <= '0;
                aa  <= op_a;
                bb  <= op_b;
                mm  <= modulus;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                acc <= acc_nx;
                bb  <= bb << 1;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run    <= 1'b0;
                    done   <= 1'b1;
                    result <= acc_nx;
                end
            end
        end
    end
endmodule

// File: rtl/mrp_modexp.sv
module mrp_modexp #(
    parameter int W = mrp_pkg::MRP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] base,
    input  logic [W-1:0] expo,
    input  logic [W-1:0] modulus,
    output logic         done,
    output logic [W-1:0] result
);
    import mrp_pkg::*;

    exp_state_t   st;
    logic [W-1:0] acc_r, pow_r, e_r, mod_r;
    logic         acc_is_one;
    logic         m_start, m_done;
    logic [W-1:0] m_a, m_b, m_res;

    mrp_modmul #(.W(W)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .start   (m_start),
        .op_a    (m_a),
        .op_b    (m_b),
        .modulus (mod_r),
        .done    (m_done),
        .result  (m_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= EX_IDLE;
            acc_r      <= '0;
            pow_r      <= '0;
            e_r        <= '0;
            mod_r      <= '0;
            acc_is_one <= 1'b1;
            m_start    <= 1'b0;
            m_a        <= '0;
            m_b        <= '0;
            done       <= 1'b0;
            result     <= '0;
        end else begin
            m_start <= 1'b0;
            done    <= 1'b0;
            case (st)
                EX_IDLE: if (start) begin
                    acc_r      <= W'(1);
                    acc_is_one <= 1'b1;
                    pow_r      <= base;
                    e_r        <= expo;
                    mod_r      <= modulus;
                    st         <= EX_CHECK;
                end
                EX_CHECK: begin
                    if (e_r == '0) begin
                        done   <= 1'b1;
                        result <= acc_r;
                        st     <= EX_IDLE;
                    end else if (e_r[0] && !acc_is_one) begin
                        m_a     <= acc_r;
                        m_b     <= pow_r;
                        m_start <= 1'b1;
                        st      <= EX_WAIT_R;
                    end else if (e_r[0]) begin
                        // first set bit: product with 1 is a plain copy
                        acc_r      <= pow_r;
                        acc_is_one <= 1'b0;
                        st         <= EX_SQUARE;
                    end else begin
                        st <= EX_SQUARE;
                    end
                end
                EX_WAIT_R: if (m_done) begin
                    acc_r <= m_res;
                    st    <= EX_SQUARE;
                end
                EX_SQUARE: begin
                    if (e_r[W-1:1] == '0) begin
                        e_r <= '0;
                        st  <= EX_CHECK;
                    end else begin
                        m_a     <= pow_r;
                        m_b     <= pow_r;
                        m_start <= 1'b1;
                        st      <= EX_WAIT_P;
                    end
                end
                EX_WAIT_P: if (m_done) begin
                    pow_r <= m_res;
                    e_r   <= e_r >> 1;
                    st    <= EX_CHECK;
                end
                default: st <= EX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mrp_split.sv
module mrp_split #(
    parameter int W  = mrp_pkg::MRP_W,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  cand,
    output logic          done,
    output logic [W-1:0]  odd_part,
    output logic [SW-1:0] twos
);
    logic run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            done     <= 1'b0;
            odd_part <= '0;
            twos     <= '0;
        end else begin
            done <= 1'b0;
            if (start && !run) begin
                odd_part <= cand - W'(1);
                twos     <= '0;
                run      <= 1'b1;
            end else if (run) begin
                if (odd_part[0]) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    odd_part <= odd_part >> 1;
                    twos     <= twos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mr_prime_tester.sv
module mr_prime_tester #(
    parameter int W = mrp_pkg::MRP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_cand,
    input  logic [2:0]   in_rounds,
    output logic         busy,
    output logic         done,
    output logic         is_prime
);
    import mrp_pkg::*;

    localparam int SW = $clog2(W);

    top_state_t    st;
    logic [W-1:0]  n_q, nm1;
    logic [2:0]    k_q, rnd;
    logic [SW-1:0] sq_cnt, sq_next;
    logic          prime_q;

    logic          s_start, s_done;
    logic [W-1:0]  d_val;
    logic [SW-1:0] s_val;

    logic          estart, edone;
    logic [W-1:0]  ebase, eexp, eres;
    logic [W-1:0]  cur_base;

    assign nm1      = n_q - W'(1);
    assign cur_base = {{(W-8){1'b0}}, witness_base(rnd)};
    assign sq_next  = sq_cnt + 1'b1;

    mrp_split #(.W(W), .SW(SW)) u_split (
        .clk      (clk),
        .rst      (rst),
        .start    (s_start),
        .cand     (n_q),
        .done     (s_done),
        .odd_part (d_val),
        .twos     (s_val)
    );

    mrp_modexp #(.W(W)) u_exp (
        .clk     (clk),
        .rst     (rst),
        .start   (estart),
        .base    (ebase),
        .expo    (eexp),
        .modulus (n_q),
        .done    (edone),
        .result  (eres)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= T_IDLE;
            n_q     <= W'(3);
            k_q     <= 3'd1;
            rnd     <= '0;
            sq_cnt  <= '0;
            prime_q <= 1'b0;
            s_start <= 1'b0;
            estart  <= 1'b0;
            ebase   <= '0;
            eexp    <= '0;
        end else begin
            s_start <= 1'b0;
            estart  <= 1'b0;
            case (st)
                T_IDLE: if (in_valid) begin
                    n_q     <= in_cand;
                    k_q     <= (in_rounds == 3'd0) ? 3'd1 : in_rounds;
                    rnd     <= '0;
                    prime_q <= 1'b0;
                    s_start <= 1'b1;
                    st      <= T_SPLIT;
                end
                T_SPLIT: if (s_done) st <= T_PICK;
                T_PICK: begin
                    if (rnd == k_q) begin
                        prime_q <= 1'b1;
                        st      <= T_FIN;
                    end else if (cur_base >= nm1) begin
                        rnd <= rnd + 1'b1;
                    end else begin
                        ebase  <= cur_base;
                        eexp   <= d_val;
                        estart <= 1'b1;
                        sq_cnt <= '0;
                        st     <= T_POW;
                    end
                end
                T_POW: if (edone) begin
                    if (eres == W'(1) || eres == nm1) begin
                        rnd <= rnd + 1'b1;
                        st  <= T_PICK;
                    end else if (s_val <= SW'(1)) begin
                        st <= T_FIN;
                    end else begin
                        ebase  <= eres;
                        eexp   <= W'(2);
                        estart <= 1'b1;
                        st     <= T_SQR;
                    end
                end
                T_SQR: if (edone) begin
                    sq_cnt <= sq_next;
                    if (eres == nm1) begin
                        rnd <= rnd + 1'b1;
                        st  <= T_PICK;
                    end else if (eres == W'(1) || sq_next == s_val - 1'b1) begin
                        st <= T_FIN;
                    end else begin
                        ebase  <= eres;
                        eexp   <= W'(2);
                        estart <= 1'b1;
                    end
                end
                T_FIN: st <= T_IDLE;
                default: st <= T_IDLE;
            endcase
        end
    end

    assign in_ready = (st == T_IDLE);
    assign busy     = (st != T_IDLE);
    assign done     = (st == T_FIN);
    assign is_prime = prime_q;
endmodule

// File: rtl/mrp_checker.sv
module mrp_checker #(
    parameter int W = mrp_pkg::MRP_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         busy,
    input logic         done,
    input logic         is_prime,
    input logic         exp_done,
    input logic [W-1:0] exp_res,
    input logic [W-1:0] mod_n
);
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !in_ready)); // R1
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R1
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R2
    AST_VERDICT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !is_prime); // R2
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(in_valid && in_ready)) |=> $stable(is_prime)); // R2
    AST_EXP_REDUCED: assert property (@(posedge clk) disable iff (rst)
        exp_done |-> (exp_res < mod_n)); // R10
endmodule

bind mr_prime_tester mrp_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .done     (done),
    .is_prime (is_prime),
    .exp_done (edone),
    .exp_res  (eres),
    .mod_n    (n_q)
);

// File: tb/tb_mr_prime_tester.sv
`timescale 1ns/1ps
module tb_mr_prime_tester;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_cand;
    logic [2:0]  in_rounds;
    logic        busy, done, is_prime;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    mr_prime_tester dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cand(in_cand), .in_rounds(in_rounds), .busy(busy),
        .done(done), .is_prime(is_prime)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            fails++;
            $display("FAIL watchdog R1: actual %0d cycles expected below 195000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint unsigned mulmod(longint unsigned a, longint unsigned b,
                                               longint unsigned m);
        return (a * b) % m;
    endfunction

    function automatic longint unsigned powmod(longint unsigned a, longint unsigned e,
                                               longint unsigned m);
        longint unsigned r = 1;
        longint unsigned p = a % m;
        while (e != 0) begin
            if (e[0]) r = mulmod(r, p, m);
            p = mulmod(p, p, m);
            e = e >> 1;
        end
        return r;
    endfunction

    // Expected verdict from R3..R9
    function automatic bit model(longint unsigned n, int k);
        longint unsigned bases[7] = '{2, 3, 5, 7, 11, 13, 17};
        longint unsigned d = n - 1;
        int s = 0;
        int kk = (k == 0) ? 1 : k;
        while (d[0] == 1'b0) begin d = d >> 1; s++; end
        for (int i = 0; i < kk; i++) begin
            longint unsigned x;
            bit ok;
            if (bases[i] >= n - 1) continue;
            x = powmod(bases[i], d, n);
            ok = (x == 1) || (x == n - 1);
            for (int j = 1; j < s && !ok; j++) begin
                x = mulmod(x, x, n);
                if (x == n - 1) ok = 1;
                else if (x == 1) break;
            end
            if (!ok) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic run_one(input logic [31:0] n, input logic [2:0] k,
                           output bit got, output int lat);
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "ready before offer", in_ready, 1);
        in_valid  = 1'b1;
        in_cand   = n;
        in_rounds = k;
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy && !in_ready, "R1", "busy after accept", {busy, in_ready}, 2);
        chk(is_prime == 1'b0, "R2", "flag cleared on accept", is_prime, 0);
        lat = 1;
        while (!done && lat < 60000) begin
            @(negedge clk);
            lat++;
            if (!done && !busy) break;
        end
        chk(done == 1'b1, "R2", "done pulse seen", done, 1);
        got = is_prime;
        @(negedge clk);
        chk(!done && !busy && in_ready && (is_prime == got), "R2",
            "pulse drops, flag held", {done, busy, in_ready, is_prime}, {3'b001, got});
    endtask

    task automatic test_vs_model(input logic [31:0] n, input logic [2:0] k, input string req);
        bit got;
        int lat;
        bit exp;
        run_one(n, k, got, lat);
        exp = model(n, k);
        chk(got == exp, req, $sformatf("verdict n=%0d k=%0d", n, k), got, exp);
    endtask

    initial begin
        bit g1, g2;
        int l1, l2;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_cand = '0; in_rounds = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(in_ready && !busy && !done && !is_prime, "R11", "reset outputs",
            {in_ready, busy, done, is_prime}, 4'b1000);

        // R8 known prime
        run_one(32'd2750263, 3'd5, g1, l1);
        chk(g1 == 1'b1, "R8", "2750263 prime", g1, 1);

        // R4 small n: every base skipped or few usable
        test_vs_model(32'd3, 3'd7, "R4");
        run_one(32'd5, 3'd7, g1, l1);
        chk(g1 == 1'b1, "R4", "n=5 prime", g1, 1);
        run_one(32'd9, 3'd3, g1, l1);
        chk(g1 == 1'b0, "R6", "n=9 composite", g1, 0);
        test_vs_model(32'd15, 3'd2, "R6");
        run_one(32'd97, 3'd7, g1, l1);
        chk(g1 == 1'b1, "R5", "n=97 prime", g1, 1);

        // R3/R5: 2047 fools base 2 only (s=1)
        run_one(32'd2047, 3'd1, g1, l1);
        chk(g1 == 1'b1, "R3", "2047 k=1 passes base 2", g1, 1);
        run_one(32'd2047, 3'd0, g2, l2);
        chk(g2 == g1, "R9", "k=0 verdict equals k=1", g2, g1);
        chk(l2 == l1, "R9", "k=0 latency equals k=1", l2, l1);
        run_one(32'd2047, 3'd2, g1, l1);
        chk(g1 == 1'b0, "R6", "2047 k=2 composite", g1, 0);
        run_one(32'd2047, 3'd7, g2, l2);
        chk(g2 == 1'b0, "R7", "2047 k=7 composite", g2, 0);
        chk(l2 == l1, "R7", "early exit latency k=7 vs k=2", l2, l1);

        // strong pseudoprime to bases 2,3,5,7
        run_one(32'd3215031751, 3'd4, g1, l1);
        chk(g1 == 1'b1, "R4", "3215031751 k=4 passes", g1, 1);
        run_one(32'd3215031751, 3'd5, g1, l1);
        chk(g1 == 1'b0, "R4", "3215031751 k=5 composite", g1, 0);

        // large prime, all 7 rounds; high s case (n-1 = 2^16 * 1 ... 65537)
        run_one(32'd4294967291, 3'd7, g1, l1);
        chk(g1 == 1'b1, "R8", "4294967291 prime", g1, 1);
        test_vs_model(32'd65537, 3'd3, "R6");
        test_vs_model(32'd4294967295, 3'd3, "R6");

        // constrained random candidates
        for (int i = 0; i < 18; i++) begin
            logic [31:0] c;
            logic [2:0]  k;
            c = $urandom() >> $urandom_range(0, 24);
            c = c | 32'd1;
            if (c < 32'd3) c = 32'd3;
            k = 3'($urandom_range(0, 7));
            test_vs_model(c, k, "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule